// File: doc/BRIEF.md
# Paged Command Register File

This block is the register store behind a power-monitor slave that speaks a byte-oriented management bus. An upstream byte engine hands it fully decoded transactions: a write carries a command byte followed by up to four data bytes, and a read asks for the register named by the most recently written command. Every access goes to the page that is currently selected. Pages 0 to 11 are margined supply channels, pages 0 to 15 are monitored voltage/current channels, and pages 16 to 20 are temperature sensors. Page 255 selects all pages at once.

Each command has its own range of valid pages. A write outside that range changes nothing. A read outside that range, or a read of a code the block does not know, returns the single byte 0xFF. Three commands are read-only: the fault log, the firmware revision and the averaged current. A write to any of them sets communication-fault flags on the current page. Software can read these flags back through the two status commands. Multi-byte values travel least-significant byte first.

A small controller sequences the work with four states:
- `ST_IDLE` waits for a request.
- `ST_WRITE` applies an accepted write.
- `ST_REJECT` answers an empty write.
- `ST_READ` presents read data.

Its transitions are:
- `IDLE->WRITE` on a write of length 1 or more.
- `IDLE->REJECT` on a write of length 0.
- `IDLE->READ` on a read.
- Every other state goes back to `IDLE` after one cycle.

Top module: `paged_cmd_regfile`

## Requirements
- R1: After reset the selected page is 0 and the latched command is 0x00. On every page, channel config (0xE4) reads 0x0020, the turn-on fault limit (0x62) reads 0xFFFF, operation (0x01) reads 0x80, on/off config (0x02) reads 0x1A and output mode (0x20) reads 0x40. All other stored registers read 0.
- R2: A request is accepted only while `busy` is low. The cycle after acceptance shows exactly one of `wr_done`, `wr_err` or `rd_done`, and the cycle after that is idle again.
- R3: Data is packed least-significant byte first. `wr_data[7:0]` is the command and `wr_data[15:8]` is the first data byte. `rd_data[7:0]` is the first byte returned. `rd_bytes` is 1, 2 or 4, and any unused upper bytes are 0.
- R4: The 16-bit commands turn-on delay (0x60), turn-on limit (0x62), turn-off delay (0x64) and margin config (0xDF), and the 32-bit sequence config (0xE8), are stored per page and act only when the page is below 12.
- R5: Power-good-on (0x5E), channel config (0xE4) and voltage peak (0xD4) are 16-bit registers stored per page. They act only when the page is below 16.
- R6: Temperature peak (0xD6) is written only on pages 16 to 20, into sensor entry page minus 16.
- R7: A temperature-peak read on a page outside 16 to 20 returns the entry for sensor 0, as 2 bytes.
- R8: A write of length 1 only latches the command code. A write of length 0 raises `wr_err` and changes neither the latched command nor any register.
- R9: Writing 0xDC, 0xE0 or 0xE2 with data stores nothing. On a page below 21 it sets bit 1 of the status word (0x79, 2 bytes) and bit 6 of the fault status byte (0x7E) for that page only.
- R10: The firmware revision (0xE0) reads 0x0001 as 2 bytes only when the page is 255. On any other page it reads 0xFF.
- R11: A read of an unknown code, or of a command outside its page range, returns 1 byte of 0xFF. A write of either kind has no effect.
- R12: Command 0x00 with data selects the page given in its first byte, and a read of 0x00 returns that page. An operation write on page 255 updates all 21 pages. A read of operation on page 255 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write transaction request |
| wr_len | input | 3 | Total bytes in the write, command included (0 to 5) |
| wr_data | input | 40 | Command in byte 0, data bytes above it, least-significant byte first |
| rd_valid | input | 1 | Read request for the latched command |
| busy | output | 1 | Controller is not idle; requests are not taken |
| wr_done | output | 1 | Write applied (or command latched) this cycle |
| wr_err | output | 1 | Empty write rejected this cycle |
| rd_done | output | 1 | Read response valid this cycle |
| rd_bytes | output | 4 | Number of valid bytes in `rd_data` |
| rd_data | output | 32 | Read response, least-significant byte first |

## Verification
The assertions assume the following about the inputs:
- `wr_valid` and `rd_valid` are never raised together.
- A request is raised only while `busy` is low.
- `wr_len` never exceeds five.

Under these assumptions, each accepted request leads to exactly one response pulse and then a return to idle. The stimulus tasks raise a single request on a falling edge and drop it one cycle later, before the response cycle. They wait out the response before the next request. The data length always matches the width of the register being written.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_REJECT = 2'd2,
        ST_READ   = 2'd3
    } pcr_state_e;

    // command codes decoded by the upstream byte engine
    localparam logic [7:0] C_PAGE      = 8'h00;
    localparam logic [7:0] C_OPER      = 8'h01;
    localparam logic [7:0] C_ONOFF     = 8'h02;
    localparam logic [7:0] C_VMODE     = 8'h20;
    localparam logic [7:0] C_PGOOD_ON  = 8'h5E;
    localparam logic [7:0] C_TON_DLY   = 8'h60;
    localparam logic [7:0] C_TON_LIM   = 8'h62;
    localparam logic [7:0] C_TOFF_DLY  = 8'h64;
    localparam logic [7:0] C_STAT_WORD = 8'h79;
    localparam logic [7:0] C_STAT_CML  = 8'h7E;
    localparam logic [7:0] C_VPEAK     = 8'hD4;
    localparam logic [7:0] C_TPEAK     = 8'hD6;
    localparam logic [7:0] C_FLOG      = 8'hDC;
    localparam logic [7:0] C_MARGIN    = 8'hDF;
    localparam logic [7:0] C_FWREV     = 8'hE0;
    localparam logic [7:0] C_IAVG      = 8'hE2;
    localparam logic [7:0] C_CHCFG     = 8'hE4;
    localparam logic [7:0] C_SEQ       = 8'hE8;

    localparam logic [7:0]  PAGE_ALL     = 8'hFF;
    localparam logic [7:0]  RST_OPER     = 8'h80;
    localparam logic [7:0]  RST_ONOFF    = 8'h1A;
    localparam logic [7:0]  RST_VMODE    = 8'h40;
    localparam logic [15:0] RST_CHCFG    = 16'h0020;
    localparam logic [15:0] RST_TON_LIM  = 16'hFFFF;
    localparam logic [31:0] NO_DATA      = 32'h0000_00FF;

endpackage

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
    import pcr_pkg::*;
#(
    parameter int LENW = 3,
    parameter int DATW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [LENW-1:0] wr_len,
    input  logic [DATW+7:0] wr_data,
    input  logic            rd_valid,
    output logic [7:0]      cmd_q,
    output logic [DATW-1:0] data_q,
    output logic            apply,
    output logic            busy,
    output logic            wr_done,
    output logic            wr_err,
    output logic            rd_done
);

    pcr_state_e state, nxt;
    logic [LENW-1:0] len_q;

    always_comb begin
        nxt = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                if (wr_valid)      nxt = (wr_len == '0) ? ST_REJECT : ST_WRITE;
                else if (rd_valid) nxt = ST_READ;
                else               nxt = ST_IDLE;
            end
            ST_WRITE:  nxt = ST_IDLE;
            ST_REJECT: nxt = ST_IDLE;
            ST_READ:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // capture of an accepted non-empty write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= C_PAGE;
            data_q <= '0;
            len_q  <= '0;
        end else if (state == ST_IDLE && wr_valid && wr_len != '0) begin
            cmd_q  <= wr_data[7:0];
            data_q <= wr_data[DATW+7:8];
            len_q  <= wr_len;
        end
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        wr_done = (state == ST_WRITE);
        wr_err  = (state == ST_REJECT);
        rd_done = (state == ST_READ);
        apply   = (state == ST_WRITE) && (len_q > LENW'(1));
    end

endmodule

// File: rtl/pcr_window.sv
module pcr_window #(
    parameter int NM   = 12,
    parameter int NMON = 16,
    parameter int NT   = 5,
    parameter int NP   = NMON + NT,
    parameter int TIW  = $clog2(NT)
) (
    input  logic [7:0]     page,
    output logic           in_margin,
    output logic           in_mon,
    output logic           in_temp,
    output logic           in_page,
    output logic           is_all,
    output logic [TIW-1:0] tidx
);

    always_comb begin
        in_margin = page < 8'(NM);
        in_mon    = page < 8'(NMON);
        in_temp   = (page >= 8'(NMON)) && (page < 8'(NMON + NT));
        in_page   = page < 8'(NP);
        is_all    = (page == 8'hFF);
        tidx      = in_temp ? TIW'(page - 8'(NMON)) : '0;
    end

endmodule

// File: rtl/pcr_store.sv
module pcr_store
    import pcr_pkg::*;
#(
    parameter int NM   = 12,
    parameter int NMON = 16,
    parameter int NT   = 5,
    parameter int NP   = NMON + NT,
    parameter int TIW  = $clog2(NT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           apply,
    input  logic [7:0]     cmd,
    input  logic [31:0]    wdat,
    input  logic           in_margin,
    input  logic           in_mon,
    input  logic           in_temp,
    input  logic           in_page,
    input  logic           is_all,
    input  logic [TIW-1:0] tidx,
    output logic [7:0]     page,
    output logic [3:0]     rbytes,
    output logic [31:0]    rdata
);

    localparam int MIW = $clog2(NM);
    localparam int OIW = $clog2(NMON);
    localparam int PW  = $clog2(NP);

    logic [15:0] ton_dly [NM];
    logic [15:0] ton_lim [NM];
    logic [15:0] toff_dly[NM];
    logic [15:0] marg    [NM];
    logic [31:0] seq     [NM];
    logic [15:0] pg_on   [NMON];
    logic [15:0] chcfg   [NMON];
    logic [15:0] vpeak   [NMON];
    logic [15:0] tpeak   [NT];
    logic [7:0]  oper    [NP];
    logic [NP-1:0] cml;

    logic [MIW-1:0] midx;
    logic [OIW-1:0] oidx;
    logic [PW-1:0]  pidx;
    logic           ro_cmd;

    always_comb begin
        midx   = page[MIW-1:0];
        oidx   = page[OIW-1:0];
        pidx   = page[PW-1:0];
        ro_cmd = (cmd == C_FLOG) || (cmd == C_FWREV) || (cmd == C_IAVG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        page <= '0;
        else if (apply && cmd == C_PAGE)   page <= wdat[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NM; i++) begin
                ton_dly[i] <= '0;  ton_lim[i] <= RST_TON_LIM;
                toff_dly[i] <= '0; marg[i] <= '0; seq[i] <= '0;
            end
        end else if (apply && in_margin) begin
            for (int i = 0; i < NM; i++) begin
                if (midx == MIW'(i)) begin
                    case (cmd)
                        C_TON_DLY:  ton_dly[i]  <= wdat[15:0];
                        C_TON_LIM:  ton_lim[i]  <= wdat[15:0];
                        C_TOFF_DLY: toff_dly[i] <= wdat[15:0];
                        C_MARGIN:   marg[i]     <= wdat[15:0];
                        C_SEQ:      seq[i]      <= wdat;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NMON; i++) begin
                pg_on[i] <= '0; chcfg[i] <= RST_CHCFG; vpeak[i] <= '0;
            end
        end else if (apply && in_mon) begin
            for (int i = 0; i < NMON; i++) begin
                if (oidx == OIW'(i)) begin
                    case (cmd)
                        C_PGOOD_ON: pg_on[i] <= wdat[15:0];
                        C_CHCFG:    chcfg[i] <= wdat[15:0];
                        C_VPEAK:    vpeak[i] <= wdat[15:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) tpeak[i] <= '0;
        end else if (apply && in_temp && cmd == C_TPEAK) begin
            for (int i = 0; i < NT; i++)
                if (tidx == TIW'(i)) tpeak[i] <= wdat[15:0];
        end
    end

    // per-page operation byte and communication-fault flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) oper[i] <= RST_OPER;
            cml <= '0;
        end else if (apply) begin
            for (int i = 0; i < NP; i++) begin
                if (cmd == C_OPER && (is_all || page == 8'(i))) oper[i] <= wdat[7:0];
                if (ro_cmd && page == 8'(i))                   cml[i]  <= 1'b1;
            end
        end
    end

    always_comb begin
        rbytes = 4'd1;
        rdata  = NO_DATA;
        case (cmd)
            C_PAGE:      rdata = {24'h0, page};
            C_OPER:      if (in_page) rdata = {24'h0, oper[pidx]};
            C_ONOFF:     if (in_page) rdata = {24'h0, RST_ONOFF};
            C_VMODE:     if (in_page) rdata = {24'h0, RST_VMODE};
            C_STAT_CML:  if (in_page) rdata = {24'h0, 1'b0, cml[pidx], 6'h0};
            C_STAT_WORD: if (in_page) begin rbytes = 4'd2; rdata = {30'h0, cml[pidx], 1'b0}; end
            C_TON_DLY:   if (in_margin) begin rbytes = 4'd2; rdata = {16'h0, ton_dly[midx]}; end
            C_TON_LIM:   if (in_margin) begin rbytes = 4'd2; rdata = {16'h0, ton_lim[midx]}; end
            C_TOFF_DLY:  if (in_margin) begin rbytes = 4'd2; rdata = {16'h0, toff_dly[midx]}; end
            C_MARGIN:    if (in_margin) begin rbytes = 4'd2; rdata = {16'h0, marg[midx]}; end
            C_SEQ:       if (in_margin) begin rbytes = 4'd4; rdata = seq[midx]; end
            C_PGOOD_ON:  if (in_mon) begin rbytes = 4'd2; rdata = {16'h0, pg_on[oidx]}; end
            C_CHCFG:     if (in_mon) begin rbytes = 4'd2; rdata = {16'h0, chcfg[oidx]}; end
            C_VPEAK:     if (in_mon) begin rbytes = 4'd2; rdata = {16'h0, vpeak[oidx]}; end
            C_IAVG:      if (in_mon) begin rbytes = 4'd2; rdata = 32'h0; end
            C_TPEAK:     begin rbytes = 4'd2; rdata = {16'h0, tpeak[tidx]}; end
            C_FLOG:      begin rbytes = 4'd4; rdata = 32'h0; end
            C_FWREV:     if (is_all) begin rbytes = 4'd2; rdata = 32'h1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/paged_cmd_regfile.sv
module paged_cmd_regfile #(
    parameter int NUM_MARGIN = 12,
    parameter int NUM_MON    = 16,
    parameter int NUM_TEMP   = 5,
    parameter int DATA_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic [$clog2(DATA_BYTES+2)-1:0] wr_len,
    input  logic [8*DATA_BYTES+7:0]       wr_data,
    input  logic                          rd_valid,
    output logic                          busy,
    output logic                          wr_done,
    output logic                          wr_err,
    output logic                          rd_done,
    output logic [3:0]                    rd_bytes,
    output logic [31:0]                   rd_data
);

    localparam int NUM_PAGES = NUM_MON + NUM_TEMP;
    localparam int LENW      = $clog2(DATA_BYTES + 2);
    localparam int DATW      = 8 * DATA_BYTES;
    localparam int TIW       = $clog2(NUM_TEMP);

    logic [7:0]      cmd_q;
    logic [DATW-1:0] data_q;
    logic            apply;
    logic [7:0]      page;
    logic            in_margin, in_mon, in_temp, in_page, is_all;
    logic [TIW-1:0]  tidx;
    logic [3:0]      st_bytes;
    logic [31:0]     st_data;

    pcr_ctrl #(.LENW(LENW), .DATW(DATW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_len(wr_len),
        .wr_data(wr_data), .rd_valid(rd_valid), .cmd_q(cmd_q), .data_q(data_q),
        .apply(apply), .busy(busy), .wr_done(wr_done), .wr_err(wr_err),
        .rd_done(rd_done)
    );

    pcr_window #(.NM(NUM_MARGIN), .NMON(NUM_MON), .NT(NUM_TEMP),
                 .NP(NUM_PAGES), .TIW(TIW)) u_win (
        .page(page), .in_margin(in_margin), .in_mon(in_mon), .in_temp(in_temp),
        .in_page(in_page), .is_all(is_all), .tidx(tidx)
    );

    pcr_store #(.NM(NUM_MARGIN), .NMON(NUM_MON), .NT(NUM_TEMP),
                .NP(NUM_PAGES), .TIW(TIW)) u_store (
        .clk(clk), .rst_n(rst_n), .apply(apply), .cmd(cmd_q), .wdat(data_q[31:0]),
        .in_margin(in_margin), .in_mon(in_mon), .in_temp(in_temp),
        .in_page(in_page), .is_all(is_all), .tidx(tidx), .page(page),
        .rbytes(st_bytes), .rdata(st_data)
    );

    always_comb begin
        rd_bytes = rd_done ? st_bytes : 4'd0;
        rd_data  = rd_done ? st_data  : 32'd0;
    end

endmodule

// File: rtl/pcr_checker.sv
module pcr_checker #(
    parameter int LENW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_valid,
    input logic [LENW-1:0] wr_len,
    input logic            rd_valid,
    input logic            busy,
    input logic            wr_done,
    input logic            wr_err,
    input logic            rd_done,
    input logic [3:0]      rd_bytes,
    input logic [31:0]     rd_data
);

    assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_valid && !wr_valid) |=> rd_done);

    assert_write_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && wr_len != '0) |=> (wr_done && !wr_err));

    assert_one_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_done, wr_done, wr_err}));

    assert_back_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done || wr_done || wr_err) |=> !busy);

    assert_empty_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_valid && wr_len == '0) |=> (wr_err && !wr_done));

    assert_resp_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (rd_bytes == 4'd1 || rd_bytes == 4'd2 || rd_bytes == 4'd4));

    assert_byte_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_bytes == 4'd1) |-> (rd_data[31:8] == 24'h0));

endmodule

bind paged_cmd_regfile pcr_checker #(.LENW(3)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_len(wr_len),
    .rd_valid(rd_valid), .busy(busy), .wr_done(wr_done), .wr_err(wr_err),
    .rd_done(rd_done), .rd_bytes(rd_bytes), .rd_data(rd_data)
);

// File: tb/paged_cmd_regfile_tb.sv
`timescale 1ns/1ps
module paged_cmd_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_len = '0;
    logic [39:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic        busy, wr_done, wr_err, rd_done;
    logic [3:0]  rd_bytes;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    paged_cmd_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_len(wr_len),
        .wr_data(wr_data), .rd_valid(rd_valid), .busy(busy), .wr_done(wr_done),
        .wr_err(wr_err), .rd_done(rd_done), .rd_bytes(rd_bytes), .rd_data(rd_data)
    );

    // {tag, page, cmd, data bytes, data, expected bytes, expected data}
    localparam int NV = 28;
    localparam logic [91:0] VEC [NV] = '{
        {4'd1,  8'd7,   8'hE4, 4'd0, 32'h0,        4'd1+4'd1, 32'h0020},   // R1 channel config
        {4'd1,  8'd0,   8'h62, 4'd0, 32'h0,        4'd2, 32'hFFFF},        // R1 turn-on limit
        {4'd1,  8'd2,   8'h01, 4'd0, 32'h0,        4'd1, 32'h80},          // R1 operation
        {4'd1,  8'd20,  8'h02, 4'd0, 32'h0,        4'd1, 32'h1A},          // R1 on/off
        {4'd1,  8'd18,  8'h20, 4'd0, 32'h0,        4'd1, 32'h40},          // R1 mode
        {4'd4,  8'd3,   8'h60, 4'd2, 32'h1234,     4'd2, 32'h1234},        // R4 R3
        {4'd4,  8'd4,   8'h60, 4'd0, 32'h0,        4'd2, 32'h0000},        // R4 neighbour page
        {4'd4,  8'd11,  8'hE8, 4'd4, 32'hDEADBEEF, 4'd4, 32'hDEADBEEF},    // R4 R3 32-bit
        {4'd4,  8'd12,  8'h60, 4'd2, 32'h5555,     4'd1, 32'hFF},          // R4 edge
        {4'd5,  8'd15,  8'h5E, 4'd2, 32'hAAAA,     4'd2, 32'hAAAA},        // R5
        {4'd5,  8'd16,  8'h5E, 4'd2, 32'h1111,     4'd1, 32'hFF},          // R5 edge
        {4'd6,  8'd20,  8'hD6, 4'd2, 32'h0BEE,     4'd2, 32'h0BEE},        // R6
        {4'd6,  8'd16,  8'hD6, 4'd2, 32'h0C0C,     4'd2, 32'h0C0C},        // R6
        {4'd6,  8'd3,   8'hD6, 4'd2, 32'h9999,     4'd2, 32'h0C0C},        // R6 R7
        {4'd7,  8'd21,  8'hD6, 4'd0, 32'h0,        4'd2, 32'h0C0C},        // R7
        {4'd10, 8'd255, 8'hE0, 4'd0, 32'h0,        4'd2, 32'h0001},        // R10
        {4'd10, 8'd4,   8'hE0, 4'd0, 32'h0,        4'd1, 32'hFF},          // R10
        {4'd9,  8'd9,   8'hE2, 4'd2, 32'h7777,     4'd2, 32'h0000},        // R9
        {4'd9,  8'd9,   8'h7E, 4'd0, 32'h0,        4'd1, 32'h40},          // R9
        {4'd9,  8'd9,   8'h79, 4'd0, 32'h0,        4'd2, 32'h0002},        // R9
        {4'd9,  8'd10,  8'h7E, 4'd0, 32'h0,        4'd1, 32'h00},          // R9 other page
        {4'd11, 8'd2,   8'h99, 4'd2, 32'h1234,     4'd1, 32'hFF},          // R11
        {4'd12, 8'd255, 8'h01, 4'd1, 32'h00,       4'd1, 32'hFF},          // R12
        {4'd12, 8'd20,  8'h01, 4'd0, 32'h0,        4'd1, 32'h00},          // R12
        {4'd12, 8'd0,   8'h01, 4'd0, 32'h0,        4'd1, 32'h00},          // R12
        {4'd12, 8'd200, 8'h00, 4'd0, 32'h0,        4'd1, 32'hC8},          // R12 page read
        {4'd11, 8'd22,  8'h01, 4'd1, 32'h5A,       4'd1, 32'hFF},          // R11
        {4'd11, 8'd21,  8'h7E, 4'd0, 32'h0,        4'd1, 32'hFF}           // R11
    };

    task automatic check(input bit ok, input string tag, input logic [35:0] act,
                         input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] len, input logic [39:0] d,
                         output logic dn, output logic er);
        @(negedge clk);
        wr_valid = 1'b1; wr_len = len; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        dn = wr_done; er = wr_err;
        @(negedge clk);
    endtask

    task automatic do_rd(output logic dn, output logic [3:0] nb, output logic [31:0] d);
        @(negedge clk);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        dn = rd_done; nb = rd_bytes; d = rd_data;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic dn, er;
        logic [3:0] nb;
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(!busy && !wr_done && !wr_err && !rd_done, "R1 idle after reset",
              {32'h0, busy, wr_done, wr_err, rd_done}, 36'h0);
        // R1: latched command is the page command, page 0
        do_rd(dn, nb, d);
        check(dn && nb == 4'd1 && d == 32'h0, "R1 page after reset", {nb, d}, {4'd1, 32'h0});

        for (int i = 0; i < NV; i++) begin
            logic [91:0] e;
            logic [3:0] tag;
            e = VEC[i];
            tag = e[91:88];
            do_wr(3'd2, {24'h0, e[87:80], 8'h00}, dn, er);
            do_wr(3'(e[71:68]) + 3'd1, {e[67:36], e[79:72]}, dn, er);
            // R2 every write acknowledged
            check(dn && !er, $sformatf("R2 write ack vec %0d", i), {34'h0, dn, er}, 36'h2);
            do_rd(dn, nb, d);
            check(dn && nb == e[35:32] && d == e[31:0],
                  $sformatf("R%0d vec %0d", tag, i), {nb, d}, e[35:0]);
        end

        // R8: empty write rejected, latched command and contents kept
        do_wr(3'd2, {24'h0, 8'd7, 8'h00}, dn, er);
        do_wr(3'd3, {16'h0, 16'hBEEF, 8'hE4}, dn, er);
        do_wr(3'd0, {16'h0, 16'h4444, 8'h60}, dn, er);
        check(!dn && er, "R8 empty write error", {34'h0, dn, er}, 36'h1);
        do_rd(dn, nb, d);
        check(dn && nb == 4'd2 && d == 32'hBEEF, "R8 state kept", {nb, d}, {4'd2, 32'hBEEF});

        // R8: command-only write switches the read target without storing
        do_wr(3'd1, {32'h0, 8'h20}, dn, er);
        check(dn && !er, "R8 latch ack", {34'h0, dn, er}, 36'h2);
        do_rd(dn, nb, d);
        check(dn && nb == 4'd1 && d == 32'h40, "R8 latch read", {nb, d}, {4'd1, 32'h40});
        do_wr(3'd1, {32'h0, 8'hE4}, dn, er);
        do_rd(dn, nb, d);
        check(dn && nb == 4'd2 && d == 32'hBEEF, "R8 value unchanged", {nb, d}, {4'd2, 32'hBEEF});

        // R3: byte lanes of a 32-bit value
        do_wr(3'd2, {24'h0, 8'd0, 8'h00}, dn, er);
        do_wr(3'd5, {32'h0403_0201, 8'hE8}, dn, er);
        do_rd(dn, nb, d);
        check(dn && nb == 4'd4 && d[7:0] == 8'h01 && d[31:24] == 8'h04,
              "R3 byte order", {nb, d}, {4'd4, 32'h0403_0201});

        // R2: idle again after the response
        @(negedge clk);
        check(!busy && !rd_done, "R2 idle after read", {34'h0, busy, rd_done}, 36'h0);

        finish_run();
    end

endmodule